// File: doc/BRIEF.md
# Serial Link Control Register Unit

This block is the control register that a CPU uses to steer a J1850-style serial data link controller. One writable register carries six control fields: a fast (4X) receive enable, a selector for the polarity of the normalization bit, an end-of-data request, and three bits that choose the kind of in-frame response to send. The link engine reports protocol events as single-cycle strobes, and some of these clear fields without any software action.

The three response-type bits read back exactly as written. Internally they pass through a priority decode into a registered one-hot command, with a separate "none" flag when no bit is set. The normalization bit value is produced combinationally from the selector and a flag from the link engine that says whether the current response ends with a CRC byte. A break symbol also loads a state vector output with a fixed code.

Top module: `slink_ctrl_reg`

## Requirements
- R1: After synchronous active-high reset, rd_data, fast_rx_en, eod_req, ifr_cmd and state_vec are all 0 and ifr_none is 1.
- R2: A write with wr_en stores wr_data bits: bit 0 = response type A (lowest priority), bit 1 = type B, bit 2 = type C (highest), bit 3 = end-of-data request, bit 4 = normalization select, bit 5 = 4X receive enable. rd_data returns these six bits in the same positions the cycle after the write, with bits above 5 reading 0; fast_rx_en and eod_req follow bits 5 and 3.
- R3: An ev_break strobe clears the 4X receive enable and loads state_vec with 0x1C on the next edge, leaving the other fields unchanged.
- R4: When ev_break coincides with a write setting bit 5, the enable ends at 0.
- R5: With ifr_active low, ev_crc_start clears the end-of-data request; with ifr_active high, ev_crc_start leaves it set.
- R6: With ifr_active high, ev_eod_rx clears the end-of-data request; with ifr_active low, ev_eod_rx leaves it set.
- R7: ev_error clears the end-of-data request in either mode, and wins over a same-cycle write that sets it.
- R8: ifr_cmd (bit 2 = C, bit 1 = B, bit 0 = A) is one-hot at the highest-priority set type bit, updated on the same edge as the register; ifr_none is 1 exactly when all three type bits are 0.
- R9: The three type bits read back as the exact pattern written, for all eight patterns.
- R10: norm_bit equals resp_has_crc when the select is 0, and its inverse when the select is 1, with no clock delay.
- R11: state_vec is not affected by writes; it changes only on reset and ev_break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read data |
| ev_break | input | 1 | Break symbol received (pulse) |
| ev_crc_start | input | 1 | First CRC bit started (pulse) |
| ev_eod_rx | input | 1 | Valid EOD received back (pulse) |
| ev_error | input | 1 | Link error detected (pulse) |
| ifr_active | input | 1 | End-of-data request is closing an in-frame response |
| resp_has_crc | input | 1 | Current response ends with a CRC byte |
| fast_rx_en | output | 1 | 4X receive-only mode enable |
| eod_req | output | 1 | End-of-data request to link engine |
| norm_bit | output | 1 | Normalization bit value |
| ifr_cmd | output | 3 | Decoded one-hot response command |
| ifr_none | output | 1 | No response type selected |
| state_vec | output | 8 | State vector output |

## Verification
The assertions take for granted that every event strobe lasts one cycle and that ifr_active is steady across an event, so a clear can be traced to a single strobe. The stimulus drives each strobe for exactly one clock, changes ifr_active only on cycles with no event, and holds writes apart from events except in the cases that test event priority on purpose. All 64 values of the six fields are swept with no events, each paired with both values of resp_has_crc.

// File: rtl/slink_ctrl_pkg.sv
package slink_ctrl_pkg;
    localparam int IFR_W      = 3;
    localparam int POS_IFR    = 0;
    localparam int POS_EOD    = 3;
    localparam int POS_NSEL   = 4;
    localparam int POS_FAST   = 5;
    localparam int USED_BITS  = 6;

    typedef struct packed {
        logic             fast;
        logic             nsel;
        logic             eod;
        logic [IFR_W-1:0] ifr;
        logic [IFR_W-1:0] cmd;
        logic             none;
    } ctrl_t;
endpackage

// File: rtl/slink_ifr_prio.sv
module slink_ifr_prio
    import slink_ctrl_pkg::*;
(
    input  logic [IFR_W-1:0] req_i,
    output logic [IFR_W-1:0] grant_o,
    output logic             none_o
);
    // highest index wins
    always_comb begin
        grant_o = '0;
        for (int i = 0; i < IFR_W; i++) begin
            if (req_i[i]) grant_o = IFR_W'(1) << i;
        end
        none_o = (req_i == '0);
    end
endmodule

// File: rtl/slink_clr_events.sv
module slink_clr_events (
    input  logic ev_break,
    input  logic ev_crc_start,
    input  logic ev_eod_rx,
    input  logic ev_error,
    input  logic ifr_active,
    output logic clr_fast,
    output logic clr_eod
);
    always_comb begin
        clr_fast = ev_break;
        clr_eod  = ev_error
                 | (ev_crc_start & ~ifr_active)
                 | (ev_eod_rx    &  ifr_active);
    end
endmodule

// File: rtl/slink_norm_gen.sv
module slink_norm_gen (
    input  logic nsel,
    input  logic has_crc,
    output logic norm
);
    assign norm = has_crc ^ nsel;
endmodule

// File: rtl/slink_ctrl_reg.sv
module slink_ctrl_reg
    import slink_ctrl_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              SV_W     = 8,
    parameter logic [SV_W-1:0] SV_BREAK = 8'h1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_break,
    input  logic              ev_crc_start,
    input  logic              ev_eod_rx,
    input  logic              ev_error,
    input  logic              ifr_active,
    input  logic              resp_has_crc,
    output logic              fast_rx_en,
    output logic              eod_req,
    output logic              norm_bit,
    output logic [IFR_W-1:0]  ifr_cmd,
    output logic              ifr_none,
    output logic [SV_W-1:0]   state_vec
);
    localparam int PAD_W = DATA_W - USED_BITS;

    ctrl_t            ctl_d, ctl_q;
    logic [SV_W-1:0]  sv_d, sv_q;
    logic [IFR_W-1:0] ifr_nxt, cmd_nxt;
    logic             none_nxt, clr_fast, clr_eod;

    slink_clr_events u_clr (
        .ev_break     (ev_break),
        .ev_crc_start (ev_crc_start),
        .ev_eod_rx    (ev_eod_rx),
        .ev_error     (ev_error),
        .ifr_active   (ifr_active),
        .clr_fast     (clr_fast),
        .clr_eod      (clr_eod)
    );

    assign ifr_nxt = wr_en ? wr_data[POS_IFR +: IFR_W] : ctl_q.ifr;

    slink_ifr_prio u_prio (
        .req_i   (ifr_nxt),
        .grant_o (cmd_nxt),
        .none_o  (none_nxt)
    );

    slink_norm_gen u_norm (
        .nsel    (ctl_q.nsel),
        .has_crc (resp_has_crc),
        .norm    (norm_bit)
    );

    always_comb begin
        ctl_d = ctl_q;
        sv_d  = sv_q;
        if (wr_en) begin
            ctl_d.fast = wr_data[POS_FAST];
            ctl_d.nsel = wr_data[POS_NSEL];
            ctl_d.eod  = wr_data[POS_EOD];
        end
        ctl_d.ifr  = ifr_nxt;
        ctl_d.cmd  = cmd_nxt;
        ctl_d.none = none_nxt;
        if (clr_fast) ctl_d.fast = 1'b0;   // event beats software
        if (clr_eod)  ctl_d.eod  = 1'b0;
        if (ev_break) sv_d = SV_BREAK;
        if (rst) begin
            ctl_d      = '0;
            ctl_d.none = 1'b1;
            sv_d       = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
        sv_q  <= sv_d;
    end

    always_comb begin
        rd_data = {{PAD_W{1'b0}}, ctl_q.fast, ctl_q.nsel, ctl_q.eod, ctl_q.ifr};
    end

    assign fast_rx_en = ctl_q.fast;
    assign eod_req    = ctl_q.eod;
    assign ifr_cmd    = ctl_q.cmd;
    assign ifr_none   = ctl_q.none;
    assign state_vec  = sv_q;

    a_r3_break_clears: assert property (@(posedge clk) disable iff (rst)
        ev_break |=> (!fast_rx_en && state_vec == SV_BREAK));

    a_r7_error_clears_eod: assert property (@(posedge clk) disable iff (rst)
        ev_error |=> !eod_req);

    a_r9_ifr_readback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[POS_IFR +: IFR_W] == $past(wr_data[POS_IFR +: IFR_W]));

    a_r8_cmd_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ifr_cmd) && (ifr_none == (rd_data[POS_IFR +: IFR_W] == '0)));

    a_r8_top_priority: assert property (@(posedge clk) disable iff (rst)
        rd_data[POS_IFR + IFR_W - 1] |-> ifr_cmd[IFR_W-1]);

    a_r5_crc_ignored_in_ifr: assert property (@(posedge clk) disable iff (rst)
        (eod_req && ifr_active && ev_crc_start && !ev_error && !ev_eod_rx && !wr_en)
        |=> eod_req);

    a_r11_sv_steady: assert property (@(posedge clk) disable iff (rst)
        !ev_break |=> $stable(state_vec));
endmodule

// File: tb/slink_ctrl_reg_bench.sv
module slink_ctrl_reg_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ev_break = 0, ev_crc_start = 0, ev_eod_rx = 0, ev_error = 0;
    logic       ifr_active = 0, resp_has_crc = 0;
    logic       fast_rx_en, eod_req, norm_bit, ifr_none;
    logic [2:0] ifr_cmd;
    logic [7:0] state_vec;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    slink_ctrl_reg u_slink_ctrl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_break(ev_break), .ev_crc_start(ev_crc_start), .ev_eod_rx(ev_eod_rx),
        .ev_error(ev_error), .ifr_active(ifr_active), .resp_has_crc(resp_has_crc),
        .fast_rx_en(fast_rx_en), .eod_req(eod_req), .norm_bit(norm_bit),
        .ifr_cmd(ifr_cmd), .ifr_none(ifr_none), .state_vec(state_vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; ev_break = 0; ev_crc_start = 0; ev_eod_rx = 0; ev_error = 0;
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1; wr_data = v;
        tick();
    endtask

    function automatic logic [2:0] prio(input logic [2:0] t);
        if (t[2]) return 3'b100;
        if (t[1]) return 3'b010;
        if (t[0]) return 3'b001;
        return 3'b000;
    endfunction

    initial begin
        @(negedge clk);
        tick(); tick();
        // R1 reset state (rst still high)
        chk("R1 rd_data", rd_data, 0);
        chk("R1 fast_rx_en", fast_rx_en, 0);
        chk("R1 eod_req", eod_req, 0);
        chk("R1 ifr_cmd", ifr_cmd, 0);
        chk("R1 ifr_none", ifr_none, 1);
        chk("R1 state_vec", state_vec, 0);
        rst = 0;
        tick();

        // R2 R8 R9 R10 sweep of all field values
        for (int v = 0; v < 64; v++) begin
            wr(8'(v) | 8'hC0);
            chk("R2 readback", rd_data, v);
            chk("R2 fast_rx_en", fast_rx_en, (v >> 5) & 1);
            chk("R2 eod_req", eod_req, (v >> 3) & 1);
            chk("R9 ifr bits", rd_data[2:0], v & 7);
            chk("R8 ifr_cmd", ifr_cmd, prio(3'(v)));
            chk("R8 ifr_none", ifr_none, ((v & 7) == 0) ? 1 : 0);
            for (int c = 0; c < 2; c++) begin
                resp_has_crc = c[0];
                #1;
                chk("R10 norm_bit", norm_bit, c ^ ((v >> 4) & 1));
            end
            chk("R11 state_vec", state_vec, 0);
        end

        // R3 break clears enable, loads state vector
        wr(8'h3F);
        ev_break = 1; tick();
        chk("R3 fast_rx_en", fast_rx_en, 0);
        chk("R3 state_vec", state_vec, 8'h1C);
        chk("R3 other fields", rd_data, 8'h1F);
        wr(8'h00);
        chk("R11 state_vec after write", state_vec, 8'h1C);

        // R4 break beats write
        wr_en = 1; wr_data = 8'h20; ev_break = 1; tick();
        chk("R4 fast_rx_en", fast_rx_en, 0);

        // R5 crc start
        ifr_active = 0; wr(8'h08);
        ev_crc_start = 1; tick();
        chk("R5 crc clears eod", eod_req, 0);
        ifr_active = 1; wr(8'h08);
        ev_crc_start = 1; tick();
        chk("R5 crc ignored in ifr", eod_req, 1);
        // R6 eod received
        ev_eod_rx = 1; tick();
        chk("R6 eod_rx clears", eod_req, 0);
        ifr_active = 0; wr(8'h08);
        ev_eod_rx = 1; tick();
        chk("R6 eod_rx ignored", eod_req, 1);
        // R7 error
        ev_error = 1; tick();
        chk("R7 error clears msg", eod_req, 0);
        ifr_active = 1; wr(8'h08);
        ev_error = 1; tick();
        chk("R7 error clears ifr", eod_req, 0);
        wr_en = 1; wr_data = 8'h08; ev_error = 1; tick();
        chk("R7 error beats write", eod_req, 0);
        chk("R7 other bits kept", rd_data, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule